// File: doc/BRIEF.md
# Quad-Lane Serial Slave Transfer Engine

This block is the slave side of a four-lane serial link. An external master drives a serial clock and an active-low select. While select is low, each rising edge of the serial clock captures one 4-bit nibble from the data lanes, and each falling edge drives the next outgoing nibble. Words are sent most significant nibble first. A frame lasts a programmable number of serial clock cycles, from 1 to 16, so a word holds 4 to 64 bits. The serial pins are oversampled and synchronised on the fast system clock, so the serial clock must be well below the system clock rate.

A local host sees a transmit holding buffer, a receive buffer and three flags: transmit-empty, receive-full and overrun. The host writes outgoing words and reads incoming words through single-cycle strobes. Only the external master starts a frame; a host write never does. The engine always sends whatever its shift register holds. If the host has queued nothing, the bits received in the last frame go back out unchanged. If the master releases select partway through a frame, the frame is dropped and the shift register is cleared.

Top module: `qspi_slave_core`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0, overrun is 0, rx_rdata is all zero and sd_oe is 0.
- R2: While ss_n is high, serial clock edges and lane inputs do not shift or complete a frame, and the tx_wr and rx_rd strobes are ignored. sd_oe is 4'hF while ss_n is low and 4'h0 while it is high.
- R3: A frame is cfg_len+1 serial clock cycles long. One nibble is captured on each rising edge, with the first nibble ending up as the most significant nibble of the word. When the frame completes, rx_rdata holds the received word in bits [4*(cfg_len+1)-1:0] with zeros above, and rx_full is set.
- R4: A word written with tx_wr is moved into the shift register when no frame is in progress, and tx_empty goes back to 1 at that move. The word's low 4*(cfg_len+1) bits are then driven on sd_o, most significant nibble first, each new nibble appearing after a falling serial clock edge.
- R5: If no word is queued between two frames, the next frame drives out the word received in the previous frame, unchanged.
- R6: Reception works with no host write at all. The first frame after reset drives out zeros.
- R7: If ss_n goes high mid-frame, the frame is dropped: rx_full does not change, the cycle count restarts, and the shift register is cleared, so a following frame with nothing queued drives zeros.
- R8: If a frame completes while rx_full is already 1, rx_rdata is overwritten with the new word and overrun is set to 1.
- R9: An rx_rd strobe clears rx_full. An ovr_clr strobe clears overrun.
- R10: tx_wr alone never starts a frame. A write made during a frame clears tx_empty until that frame ends and does not change the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_n | input | 1 | Active-low select from the master |
| sclk | input | 1 | Serial clock from the master, idles low |
| sd_i | input | 4 | Data lane inputs |
| sd_o | output | 4 | Data lane outputs |
| sd_oe | output | 4 | Per-lane output enable |
| cfg_len | input | 4 | Frame length in cycles, minus one |
| tx_wr | input | 1 | Host strobe: load tx_wdata into the transmit buffer |
| tx_wdata | input | 64 | Host transmit word |
| rx_rd | input | 1 | Host strobe: acknowledge the receive buffer |
| rx_rdata | output | 64 | Receive buffer contents |
| ovr_clr | input | 1 | Host strobe: clear the overrun flag |
| tx_empty | output | 1 | Transmit buffer holds no pending word |
| rx_full | output | 1 | Receive buffer holds an unread word |
| overrun | output | 1 | A word was overwritten before it was read |

## Verification
Directed frames test the paths that are easy to confuse. A frame with nothing ever queued must drive zeros, while a frame with nothing newly queued must echo the previous input; these two cases separate echo from a stale or zeroed register. A write in the middle of a frame shows whether the word on the lanes is replaced early or only after the frame ends. A frame aborted by select, followed by a full frame, shows whether the shift register was cleared or left holding partial data. Edges sent while deselected show whether gating really holds. Randomly chosen lengths, words and host actions, checked against a 64-bit shift-register model kept in the bench, then test recirculation across frames of different lengths and the receive-full and overrun bookkeeping.

// File: rtl/qspi_slv_pkg.sv
package qspi_slv_pkg;

    localparam int DEF_LANES   = 4;
    localparam int DEF_MAX_CYC = 16;
    localparam int DEF_STAGES  = 2;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SHIFT = 1'b1
    } phase_e;

endpackage

// File: rtl/qspi_slv_sync.sv
module qspi_slv_sync #(
    parameter int              W       = 6,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stg
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/qspi_slv_shifter.sv
module qspi_slv_shifter
    import qspi_slv_pkg::*;
#(
    parameter int LANES   = DEF_LANES,
    parameter int MAX_CYC = DEF_MAX_CYC,
    parameter int LEN_W   = $clog2(MAX_CYC),
    parameter int SH_W    = LANES * MAX_CYC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             sclk_lvl,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic [LANES-1:0] din,
    input  logic [LEN_W-1:0] len,
    input  logic             tx_valid,
    input  logic [SH_W-1:0]  tx_word,
    output logic             tx_take,
    output logic             done,
    output logic [SH_W-1:0]  rx_word,
    output logic [LANES-1:0] dout
);

    typedef struct packed {
        logic [SH_W-1:0]  sh;
        logic [LEN_W-1:0] cnt;
        phase_e           ph;
        logic [LANES-1:0] dout;
    } shf_st_t;

    shf_st_t st_q, st_d;

    function automatic logic [LANES-1:0] lead_nib(input logic [SH_W-1:0] v,
                                                  input logic [LEN_W-1:0] l);
        return LANES'(v >> (LANES * int'(l)));
    endfunction

    function automatic logic [SH_W-1:0] word_mask(input logic [LEN_W-1:0] l);
        return {SH_W{1'b1}} >> (SH_W - LANES * (int'(l) + 1));
    endfunction

    logic edge_in;
    assign edge_in = sel && sclk_rise;

    always_comb begin
        st_d    = st_q;
        tx_take = 1'b0;
        done    = 1'b0;
        rx_word = '0;

        if (!sel) begin
            if (st_q.ph == PH_SHIFT) begin
                st_d.ph  = PH_IDLE;
                st_d.cnt = '0;
                st_d.sh  = '0;
            end
        end else if (sclk_rise) begin
            st_d.sh = {st_q.sh[SH_W-LANES-1:0], din};
            st_d.ph = PH_SHIFT;
            if (st_q.cnt == len) begin
                done     = 1'b1;
                st_d.cnt = '0;
                st_d.ph  = PH_IDLE;
                rx_word  = st_d.sh & word_mask(len);
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (st_q.ph == PH_IDLE && st_d.ph == PH_IDLE && !edge_in && tx_valid) begin
            st_d.sh = tx_word;
            tx_take = 1'b1;
        end

        if (sel && sclk_fall) begin
            st_d.dout = lead_nib(st_q.sh, len);
        end else if (st_d.ph == PH_IDLE && !sclk_lvl) begin
            st_d.dout = lead_nib(st_d.sh, len);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sh: '0, cnt: '0, ph: PH_IDLE, dout: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.dout;

    // R7
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && st_q.ph == PH_SHIFT) |=> (st_q.ph == PH_IDLE && st_q.cnt == '0 && st_q.sh == '0));

    // R3
    cnt_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_SHIFT) |-> (st_q.cnt <= len));

    // R4
    load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> (st_q.ph == PH_IDLE));

    // R2
    no_done_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !done);

endmodule

// File: rtl/qspi_slv_bufs.sv
module qspi_slv_bufs #(
    parameter int SH_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            wr_tx,
    input  logic [SH_W-1:0] wdata,
    input  logic            rd_rx,
    input  logic            ovr_clr,
    input  logic            tx_take,
    input  logic            done,
    input  logic [SH_W-1:0] rx_word,
    output logic            tx_valid,
    output logic [SH_W-1:0] tx_word,
    output logic [SH_W-1:0] rx_data,
    output logic            rx_full,
    output logic            ovr
);

    typedef struct packed {
        logic [SH_W-1:0] tx_buf;
        logic            tx_full;
        logic [SH_W-1:0] rx_buf;
        logic            rx_full;
        logic            ovr;
    } buf_st_t;

    buf_st_t b_q, b_d;

    logic wr_ok, rd_ok;
    assign wr_ok = sel && wr_tx;
    assign rd_ok = sel && rd_rx;

    always_comb begin
        b_d = b_q;
        if (tx_take) b_d.tx_full = 1'b0;
        if (wr_ok) begin
            b_d.tx_buf  = wdata;
            b_d.tx_full = 1'b1;
        end
        if (rd_ok)   b_d.rx_full = 1'b0;
        if (ovr_clr) b_d.ovr     = 1'b0;
        if (done) begin
            b_d.rx_buf  = rx_word;
            b_d.rx_full = 1'b1;
            if (b_q.rx_full && !rd_ok) b_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '{tx_buf: '0, tx_full: 1'b0, rx_buf: '0, rx_full: 1'b0, ovr: 1'b0};
        end else begin
            b_q <= b_d;
        end
    end

    assign tx_valid = b_q.tx_full;
    assign tx_word  = b_q.tx_buf;
    assign rx_data  = b_q.rx_buf;
    assign rx_full  = b_q.rx_full;
    assign ovr      = b_q.ovr;

    // R8
    ovr_on_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && b_q.rx_full && !rd_ok) |=> b_q.ovr);

    // R2
    gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && wr_tx && !b_q.tx_full) |=> !b_q.tx_full);

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && !done) |=> !b_q.rx_full);

    // R3
    full_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (b_q.rx_full && b_q.rx_buf == $past(rx_word)));

endmodule

// File: rtl/qspi_slave_core.sv
module qspi_slave_core
    import qspi_slv_pkg::*;
#(
    parameter int LANES   = DEF_LANES,
    parameter int MAX_CYC = DEF_MAX_CYC,
    parameter int STAGES  = DEF_STAGES,
    parameter int LEN_W   = $clog2(MAX_CYC),
    parameter int SH_W    = LANES * MAX_CYC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ss_n,
    input  logic             sclk,
    input  logic [LANES-1:0] sd_i,
    output logic [LANES-1:0] sd_o,
    output logic [LANES-1:0] sd_oe,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             tx_wr,
    input  logic [SH_W-1:0]  tx_wdata,
    input  logic             rx_rd,
    output logic [SH_W-1:0]  rx_rdata,
    input  logic             ovr_clr,
    output logic             tx_empty,
    output logic             rx_full,
    output logic             overrun
);

    localparam int              SYNC_W   = LANES + 2;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {(LANES + 1){1'b0}}};

    typedef struct packed {
        logic sclk_prev;
    } edge_st_t;

    logic [SYNC_W-1:0] pins_s;
    logic              ss_n_s, sclk_s;
    logic [LANES-1:0]  sd_s;

    qspi_slv_sync #(
        .W       (SYNC_W),
        .STAGES  (STAGES),
        .RST_VAL (SYNC_RST)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n, sclk, sd_i}),
        .q     (pins_s)
    );

    assign {ss_n_s, sclk_s, sd_s} = pins_s;

    edge_st_t e_q, e_d;

    always_comb begin
        e_d           = e_q;
        e_d.sclk_prev = sclk_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{sclk_prev: 1'b0};
        else        e_q <= e_d;
    end

    logic sel, sclk_rise, sclk_fall;
    assign sel       = !ss_n_s;
    assign sclk_rise = sclk_s && !e_q.sclk_prev;
    assign sclk_fall = !sclk_s && e_q.sclk_prev;

    logic            tx_valid, tx_take, frame_done;
    logic [SH_W-1:0] tx_word, rx_word;

    qspi_slv_shifter #(
        .LANES   (LANES),
        .MAX_CYC (MAX_CYC),
        .LEN_W   (LEN_W),
        .SH_W    (SH_W)
    ) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .sclk_lvl  (sclk_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din       (sd_s),
        .len       (cfg_len),
        .tx_valid  (tx_valid),
        .tx_word   (tx_word),
        .tx_take   (tx_take),
        .done      (frame_done),
        .rx_word   (rx_word),
        .dout      (sd_o)
    );

    logic ovr_flag;

    qspi_slv_bufs #(
        .SH_W (SH_W)
    ) bufs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .wr_tx    (tx_wr),
        .wdata    (tx_wdata),
        .rd_rx    (rx_rd),
        .ovr_clr  (ovr_clr),
        .tx_take  (tx_take),
        .done     (frame_done),
        .rx_word  (rx_word),
        .tx_valid (tx_valid),
        .tx_word  (tx_word),
        .rx_data  (rx_rdata),
        .rx_full  (rx_full),
        .ovr      (ovr_flag)
    );

    assign tx_empty = !tx_valid;
    assign overrun  = ovr_flag;
    assign sd_oe    = {LANES{sel}};

    // R2
    rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !sel) |-> !frame_done);

    // R4
    take_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> tx_valid);

    // R4
    empty_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && !(tx_wr && sel)) |=> tx_empty);

endmodule

// File: tb/qspi_slave_core_tb.sv
module qspi_slave_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ss_n = 1'b1;
    logic        sclk = 1'b0;
    logic [3:0]  sd_i = '0;
    logic [3:0]  sd_o, sd_oe;
    logic [3:0]  cfg_len = 4'd3;
    logic        tx_wr = 1'b0;
    logic [63:0] tx_wdata = '0;
    logic        rx_rd = 1'b0;
    logic [63:0] rx_rdata;
    logic        ovr_clr = 1'b0;
    logic        tx_empty, rx_full, overrun;

    always #5 clk = ~clk;

    qspi_slave_core dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ss_n     (ss_n),
        .sclk     (sclk),
        .sd_i     (sd_i),
        .sd_o     (sd_o),
        .sd_oe    (sd_oe),
        .cfg_len  (cfg_len),
        .tx_wr    (tx_wr),
        .tx_wdata (tx_wdata),
        .rx_rd    (rx_rd),
        .rx_rdata (rx_rdata),
        .ovr_clr  (ovr_clr),
        .tx_empty (tx_empty),
        .rx_full  (rx_full),
        .overrun  (overrun)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] m_sh = '0;
    logic [63:0] m_rx = '0;
    bit          m_rxf = 1'b0;
    bit          m_ovr = 1'b0;

    function automatic logic [63:0] msk(input int l);
        if (l >= 15) return '1;
        return (64'd1 << (4 * (l + 1))) - 64'd1;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic select_on();
        ss_n = 1'b0;
        wait_n(6);
    endtask

    task automatic select_off();
        ss_n = 1'b1;
        wait_n(6);
    endtask

    task automatic host_write(input logic [63:0] w);
        tx_wdata = w;
        tx_wr = 1'b1;
        wait_n(1);
        tx_wr = 1'b0;
        wait_n(4);
    endtask

    task automatic host_read();
        rx_rd = 1'b1;
        wait_n(1);
        rx_rd = 1'b0;
        wait_n(2);
    endtask

    task automatic host_ovr_clear();
        ovr_clr = 1'b1;
        wait_n(1);
        ovr_clr = 1'b0;
        wait_n(2);
    endtask

    // drives serial cycles first..first+cnt-1 of a frame of length len
    task automatic run_cycles(input int len, input logic [63:0] din,
                              input int first, input int cnt,
                              output logic [63:0] got);
        got = '0;
        for (int i = first; i < first + cnt; i++) begin
            sd_i = din[4 * (len - i) +: 4];
            wait_n(8);
            got = {got[59:0], sd_o};
            sclk = 1'b1;
            wait_n(8);
            sclk = 1'b0;
        end
        wait_n(8);
    endtask

    task automatic model_done(input int len, input logic [63:0] din);
        if (m_rxf) m_ovr = 1'b1;
        m_rxf = 1'b1;
        m_sh = (m_sh << (4 * (len + 1))) | (din & msk(len));
        m_rx = m_sh & msk(len);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] got, got1, din, w;
        int len;

        void'($urandom(32'd20240611));
        wait_n(4);
        rst_n = 1'b1;
        wait_n(4);

        // R1 reset state
        chk("R1", "tx_empty", 64'(tx_empty), 64'd1);
        chk("R1", "rx_full", 64'(rx_full), 64'd0);
        chk("R1", "overrun", 64'(overrun), 64'd0);
        chk("R1", "rx_rdata", rx_rdata, 64'd0);
        chk("R1", "sd_oe", 64'(sd_oe), 64'd0);

        // R6 first frame, no host write
        cfg_len = 4'd3;
        select_on();
        chk("R2", "sd_oe selected", 64'(sd_oe), 64'hF);
        din = 64'hA5C3;
        run_cycles(3, din, 0, 4, got);
        chk("R6", "out first frame", got, 64'd0);
        model_done(3, din);
        chk("R3", "rx_rdata", rx_rdata, m_rx);
        chk("R3", "rx_full", 64'(rx_full), 64'd1);
        host_read();
        m_rxf = 1'b0;
        chk("R9", "rx_full after read", 64'(rx_full), 64'd0);
        select_off();
        chk("R2", "sd_oe deselected", 64'(sd_oe), 64'h0);

        // R5 echo of received word
        select_on();
        din = 64'h1234;
        run_cycles(3, din, 0, 4, got);
        chk("R5", "echo", got, 64'hA5C3);
        model_done(3, din);
        chk("R3", "rx_rdata 2", rx_rdata, m_rx);
        host_read();
        m_rxf = 1'b0;
        select_off();

        // R2 gating while deselected
        host_write(64'hDEAD);
        chk("R2", "write ignored", 64'(tx_empty), 64'd1);
        run_cycles(3, 64'h9999, 0, 4, got);
        chk("R2", "no frame", 64'(rx_full), 64'd0);
        select_on();
        din = 64'h0F0F;
        run_cycles(3, din, 0, 4, got);
        chk("R2", "shift reg kept", got, 64'h1234);
        model_done(3, din);
        select_off();
        host_read();
        chk("R2", "read ignored", 64'(rx_full), 64'd1);
        select_on();
        host_read();
        m_rxf = 1'b0;
        chk("R9", "read while selected", 64'(rx_full), 64'd0);

        // R10 write alone starts nothing; R4 word goes out
        host_write(64'hCAFE);
        wait_n(40);
        chk("R10", "no self-start", 64'(rx_full), 64'd0);
        chk("R4", "empty after load", 64'(tx_empty), 64'd1);
        m_sh = 64'hCAFE;
        din = 64'h0000;
        run_cycles(3, din, 0, 4, got);
        chk("R4", "tx word out", got, 64'hCAFE);
        model_done(3, din);
        host_read();
        m_rxf = 1'b0;

        // R10 write during frame
        din = 64'h7E81;
        run_cycles(3, din, 0, 1, got1);
        host_write(64'hBEEF);
        chk("R10", "empty cleared mid-frame", 64'(tx_empty), 64'd0);
        run_cycles(3, din, 1, 3, got);
        chk("R10", "current word kept", (got1 << 12) | got, m_sh & msk(3));
        model_done(3, din);
        wait_n(4);
        chk("R4", "empty after frame", 64'(tx_empty), 64'd1);
        m_sh = 64'hBEEF;
        host_read();
        m_rxf = 1'b0;
        din = 64'h3C3C;
        run_cycles(3, din, 0, 4, got);
        chk("R4", "queued word out", got, 64'hBEEF);
        model_done(3, din);
        host_read();
        m_rxf = 1'b0;
        select_off();

        // R7 abort
        select_on();
        run_cycles(3, 64'h5A5A, 0, 2, got);
        select_off();
        chk("R7", "no rx_full", 64'(rx_full), 64'd0);
        m_sh = '0;
        select_on();
        din = 64'h6D2B;
        run_cycles(3, din, 0, 4, got);
        chk("R7", "cleared reg", got, 64'd0);
        model_done(3, din);
        chk("R7", "restart count", rx_rdata, 64'h6D2B);

        // R8 overrun
        din = 64'h4411;
        run_cycles(3, din, 0, 4, got);
        model_done(3, din);
        chk("R8", "overrun", 64'(overrun), 64'd1);
        chk("R8", "overwritten", rx_rdata, 64'h4411);
        host_ovr_clear();
        m_ovr = 1'b0;
        chk("R9", "overrun clear", 64'(overrun), 64'd0);
        host_read();
        m_rxf = 1'b0;

        // R3 boundary lengths
        cfg_len = 4'd15;
        w = 64'h0123456789ABCDEF;
        host_write(w);
        m_sh = w;
        din = 64'hFEDCBA9876543210;
        run_cycles(15, din, 0, 16, got);
        chk("R3", "len 15 out", got, w);
        model_done(15, din);
        chk("R3", "len 15 rx", rx_rdata, din);
        host_read();
        m_rxf = 1'b0;
        cfg_len = 4'd0;
        din = 64'h7;
        run_cycles(0, din, 0, 1, got);
        chk("R3", "len 0 out", got, m_sh & msk(0));
        model_done(0, din);
        chk("R3", "len 0 rx", rx_rdata, 64'h7);
        host_read();
        m_rxf = 1'b0;
        select_off();

        // random frames
        for (int k = 0; k < 40; k++) begin
            len = int'($urandom_range(15, 0));
            cfg_len = 4'(len);
            select_on();
            if ($urandom_range(1, 0) == 1) begin
                w = {$urandom, $urandom};
                host_write(w);
                m_sh = w;
            end
            din = {$urandom, $urandom};
            run_cycles(len, din, 0, len + 1, got);
            chk("R5", "random out", got, m_sh & msk(len));
            model_done(len, din);
            chk("R3", "random rx", rx_rdata, m_rx);
            chk("R8", "random flags", {62'd0, rx_full, overrun}, {62'd0, m_rxf, m_ovr});
            chk("R4", "random tx_empty", 64'(tx_empty), 64'd1);
            if ($urandom_range(9, 0) < 6) begin
                host_read();
                m_rxf = 1'b0;
            end
            if ($urandom_range(1, 0) == 1) begin
                host_ovr_clear();
                m_ovr = 1'b0;
            end
            select_off();
        end

        summary();
        $finish;
    end

endmodule